// File: doc/BRIEF.md
# Utilization Probe Best-Hop Table

This block sits in a switch pipeline and consumes path-utilization probes arriving on any of its ports. Each probe names a destination top-of-rack switch and the worst (bottleneck) utilization seen along the path it came from. The block folds in the utilization of the local link the probe arrived on, then compares the result with what it already knows for that destination. For each destination it keeps a single entry: the best next-hop port and that path's bottleneck utilization.

Whenever an entry changes, the block emits a one-cycle update strobe carrying the destination and the new utilization, so that replication logic can forward a fresh probe upstream. Forwarding logic on the data side uses a separate lookup port to fetch the current best hop for a destination. Link utilization values are inputs to the block. It accepts at most one probe per clock through a valid/ready handshake.

Top module: `probe_besthop_table`

## Requirements
- R1: While `rst_n` is low and for the synchronizer cycles after its release, `probe_ready` is 0. Reset empties every table entry, and the lookup port then reports `lkp_valid` = 0 for every destination.
- R2: After reset, `probe_ready` stays 1. A probe is taken on each rising edge where `probe_valid` and `probe_ready` are both 1, so back-to-back probes are all taken. A cycle with `probe_valid` = 0 changes nothing.
- R3: Path utilization is the larger of the probe's value and `link_util` lane `probe_port`, where lane k is bits [8k+7:8k]. Each operand is clamped to 100 before the comparison.
- R4: A probe for an empty destination always installs itself: the arrival port becomes the hop and the path utilization becomes the stored value. An empty entry ranks worse than any value, including 100.
- R5: A probe from a port other than the stored hop replaces both hop and utilization only when its path utilization is strictly lower than the stored one.
- R6: A probe from another port with equal or higher path utilization leaves the entry unchanged and raises no update.
- R7: A probe from the stored hop always overwrites the stored utilization, even when the new value is worse.
- R8: `upd_valid` is high for exactly the cycle after an accepted probe that changed its entry. In that cycle `upd_dest` holds the probe's destination and `upd_util` holds the new stored utilization. A probe that leaves the entry unchanged raises no update.
- R9: The lookup port is registered. After a rising edge, `lkp_valid`, `lkp_hop` and `lkp_util` show the entry selected by `lkp_dest`, as it stood before that edge.
- R10: Entries for different destinations are independent of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_valid | input | 1 | Probe offered this cycle |
| probe_ready | output | 1 | Block can take a probe |
| probe_dest | input | 4 | Destination identifier of the probe |
| probe_port | input | 2 | Port the probe arrived on |
| probe_util | input | 8 | Bottleneck utilization carried by the probe, percent |
| link_util | input | 32 | Local link utilization per port, 8 bits per lane |
| upd_valid | output | 1 | Entry changed; propagate a probe |
| upd_dest | output | 4 | Destination of the changed entry |
| upd_util | output | 8 | New best utilization for that destination |
| lkp_dest | input | 4 | Destination to look up |
| lkp_valid | output | 1 | Looked-up entry holds a route |
| lkp_hop | output | 2 | Best next-hop port for the looked-up destination |
| lkp_util | output | 8 | Best path utilization for the looked-up destination |

## Verification
The bench covers tie cases, where an equal utilization from a new port must not move the hop. A design that used a non-strict comparison would flap between ports and emit spurious updates. It drives values above 100 and a 100 probe into an empty entry, which exposes a missing clamp or an empty entry treated as utilization 100. It also sends a worse probe from the current hop, which a design lacking refresh would ignore. Unused link lanes hold a distinct value, so a wrong lane select changes the result, and back-to-back probes to one destination expose a stale read in the update path.

// File: rtl/pbh_pkg.sv
package pbh_pkg;

  localparam int          PBH_UTIL_W   = 8;
  localparam int unsigned PBH_UTIL_CAP = 100;

  // Outcome of comparing a probe against the stored entry
  typedef enum logic [1:0] {
    ACT_KEEP    = 2'd0,
    ACT_INSTALL = 2'd1,
    ACT_IMPROVE = 2'd2,
    ACT_REFRESH = 2'd3
  } pbh_act_e;

endpackage

// File: rtl/pbh_path_metric.sv
module pbh_path_metric #(
  parameter int          NUM_PORTS = 4,
  parameter int          UTIL_W    = pbh_pkg::PBH_UTIL_W,
  parameter int unsigned UTIL_CAP  = pbh_pkg::PBH_UTIL_CAP,
  localparam int         PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [PORT_W-1:0]           in_port,
  input  logic [UTIL_W-1:0]           probe_util,
  input  logic [NUM_PORTS*UTIL_W-1:0] link_util,
  output logic [UTIL_W-1:0]           path_util
);

  localparam logic [UTIL_W-1:0] CAP = UTIL_W'(UTIL_CAP);

  logic [UTIL_W-1:0] lane_sat [NUM_PORTS];
  logic [UTIL_W-1:0] probe_sat;
  logic [UTIL_W-1:0] link_sel;

  generate
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_lane
      logic [UTIL_W-1:0] raw;
      assign raw         = link_util[g*UTIL_W +: UTIL_W];
      assign lane_sat[g] = (raw > CAP) ? CAP : raw;
    end
  endgenerate

  always_comb begin
    probe_sat = (probe_util > CAP) ? CAP : probe_util;
    link_sel  = lane_sat[in_port];
    path_util = (link_sel > probe_sat) ? link_sel : probe_sat;
  end

endmodule

// File: rtl/pbh_entry_decide.sv
module pbh_entry_decide #(
  parameter int HOP_W  = 2,
  parameter int UTIL_W = pbh_pkg::PBH_UTIL_W
) (
  input  logic              cur_vld,
  input  logic [HOP_W-1:0]  cur_hop,
  input  logic [UTIL_W-1:0] cur_util,
  input  logic [HOP_W-1:0]  in_port,
  input  logic [UTIL_W-1:0] path_util,
  output pbh_pkg::pbh_act_e act,
  output logic              changes
);

  import pbh_pkg::*;

  always_comb begin
    if (!cur_vld) begin
      act = ACT_INSTALL;
    end else if (in_port == cur_hop) begin
      act = (path_util != cur_util) ? ACT_REFRESH : ACT_KEEP;
    end else if (path_util < cur_util) begin
      act = ACT_IMPROVE;
    end else begin
      act = ACT_KEEP;
    end
    changes = (act != ACT_KEEP);
  end

endmodule

// File: rtl/pbh_table.sv
module pbh_table #(
  parameter int  NUM_DEST = 16,
  parameter int  HOP_W    = 2,
  parameter int  UTIL_W   = pbh_pkg::PBH_UTIL_W,
  localparam int DEST_W   = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DEST_W-1:0] wr_dest,
  input  logic [HOP_W-1:0]  wr_hop,
  input  logic [UTIL_W-1:0] wr_util,
  input  logic [DEST_W-1:0] rmw_dest,
  output logic              rmw_vld,
  output logic [HOP_W-1:0]  rmw_hop,
  output logic [UTIL_W-1:0] rmw_util,
  input  logic [DEST_W-1:0] lkp_dest,
  output logic              lkp_vld_q,
  output logic [HOP_W-1:0]  lkp_hop_q,
  output logic [UTIL_W-1:0] lkp_util_q
);

  logic              vld_q  [NUM_DEST];
  logic [HOP_W-1:0]  hop_q  [NUM_DEST];
  logic [UTIL_W-1:0] util_q [NUM_DEST];

  generate
    for (genvar g = 0; g < NUM_DEST; g++) begin : g_ent
      logic ent_we;
      assign ent_we = wr_en && (wr_dest == DEST_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[g]  <= 1'b0;
          hop_q[g]  <= '0;
          util_q[g] <= '0;
        end else if (ent_we) begin
          vld_q[g]  <= 1'b1;
          hop_q[g]  <= wr_hop;
          util_q[g] <= wr_util;
        end
      end
    end
  endgenerate

  // Combinational read for the probe update path
  always_comb begin
    rmw_vld  = vld_q[rmw_dest];
    rmw_hop  = hop_q[rmw_dest];
    rmw_util = util_q[rmw_dest];
  end

  // Registered read for the forwarding side
  logic              lkp_vld_d;
  logic [HOP_W-1:0]  lkp_hop_d;
  logic [UTIL_W-1:0] lkp_util_d;

  always_comb begin
    lkp_vld_d  = vld_q[lkp_dest];
    lkp_hop_d  = hop_q[lkp_dest];
    lkp_util_d = util_q[lkp_dest];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lkp_vld_q  <= 1'b0;
      lkp_hop_q  <= '0;
      lkp_util_q <= '0;
    end else begin
      lkp_vld_q  <= lkp_vld_d;
      lkp_hop_q  <= lkp_hop_d;
      lkp_util_q <= lkp_util_d;
    end
  end

endmodule

// File: rtl/probe_besthop_table.sv
module probe_besthop_table #(
  parameter int          NUM_DEST  = 16,
  parameter int          NUM_PORTS = 4,
  parameter int          UTIL_W    = pbh_pkg::PBH_UTIL_W,
  parameter int unsigned UTIL_CAP  = pbh_pkg::PBH_UTIL_CAP,
  localparam int         DEST_W    = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
  localparam int         PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        probe_valid,
  output logic                        probe_ready,
  input  logic [DEST_W-1:0]           probe_dest,
  input  logic [PORT_W-1:0]           probe_port,
  input  logic [UTIL_W-1:0]           probe_util,
  input  logic [NUM_PORTS*UTIL_W-1:0] link_util,
  output logic                        upd_valid,
  output logic [DEST_W-1:0]           upd_dest,
  output logic [UTIL_W-1:0]           upd_util,
  input  logic [DEST_W-1:0]           lkp_dest,
  output logic                        lkp_valid,
  output logic [PORT_W-1:0]           lkp_hop,
  output logic [UTIL_W-1:0]           lkp_util
);

  // Reset: asserted asynchronously, released on the clock
  logic sync_q1, sync_q2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q1 <= 1'b0;
      sync_q2 <= 1'b0;
    end else begin
      sync_q1 <= 1'b1;
      sync_q2 <= sync_q1;
    end
  end

  logic core_rst_n;
  assign core_rst_n = sync_q2;

  logic ready_q;
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) ready_q <= 1'b0;
    else             ready_q <= 1'b1;
  end
  assign probe_ready = ready_q;

  logic accept;
  assign accept = probe_valid && ready_q;

  // Path metric
  logic [UTIL_W-1:0] path_util;
  pbh_path_metric #(
    .NUM_PORTS (NUM_PORTS),
    .UTIL_W    (UTIL_W),
    .UTIL_CAP  (UTIL_CAP)
  ) u_metric (
    .in_port    (probe_port),
    .probe_util (probe_util),
    .link_util  (link_util),
    .path_util  (path_util)
  );

  // Table
  logic              cur_vld;
  logic [PORT_W-1:0] cur_hop;
  logic [UTIL_W-1:0] cur_util;
  logic              wr_en;
  logic              entry_changes;
  pbh_pkg::pbh_act_e act;

  pbh_table #(
    .NUM_DEST (NUM_DEST),
    .HOP_W    (PORT_W),
    .UTIL_W   (UTIL_W)
  ) u_table (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .wr_en      (wr_en),
    .wr_dest    (probe_dest),
    .wr_hop     (probe_port),
    .wr_util    (path_util),
    .rmw_dest   (probe_dest),
    .rmw_vld    (cur_vld),
    .rmw_hop    (cur_hop),
    .rmw_util   (cur_util),
    .lkp_dest   (lkp_dest),
    .lkp_vld_q  (lkp_valid),
    .lkp_hop_q  (lkp_hop),
    .lkp_util_q (lkp_util)
  );

  pbh_entry_decide #(
    .HOP_W  (PORT_W),
    .UTIL_W (UTIL_W)
  ) u_decide (
    .cur_vld   (cur_vld),
    .cur_hop   (cur_hop),
    .cur_util  (cur_util),
    .in_port   (probe_port),
    .path_util (path_util),
    .act       (act),
    .changes   (entry_changes)
  );

  assign wr_en = accept && entry_changes;

  // Update strobe: next-state and register
  logic              upd_valid_d;
  logic [DEST_W-1:0] upd_dest_d;
  logic [UTIL_W-1:0] upd_util_d;

  always_comb begin
    upd_valid_d = wr_en;
    upd_dest_d  = upd_dest;
    upd_util_d  = upd_util;
    if (wr_en) begin
      upd_dest_d = probe_dest;
      upd_util_d = path_util;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      upd_valid <= 1'b0;
      upd_dest  <= '0;
      upd_util  <= '0;
    end else begin
      upd_valid <= upd_valid_d;
      upd_dest  <= upd_dest_d;
      upd_util  <= upd_util_d;
    end
  end

endmodule

// File: rtl/pbh_checker.sv
module pbh_checker #(
  parameter int          DEST_W   = 4,
  parameter int          UTIL_W   = 8,
  parameter int unsigned UTIL_CAP = 100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              probe_valid,
  input logic              probe_ready,
  input logic [DEST_W-1:0] probe_dest,
  input logic [UTIL_W-1:0] probe_util,
  input logic              upd_valid,
  input logic [DEST_W-1:0] upd_dest,
  input logic [UTIL_W-1:0] upd_util,
  input logic              lkp_valid,
  input logic [UTIL_W-1:0] lkp_util
);

  localparam logic [UTIL_W-1:0] CAP = UTIL_W'(UTIL_CAP);

  assert_upd_needs_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $past(probe_valid && probe_ready));

  assert_upd_dest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (upd_dest == $past(probe_dest)));

  assert_upd_capped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (upd_util <= CAP));

  assert_path_not_below_probe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && ($past(probe_util) <= CAP)) |-> (upd_util >= $past(probe_util)));

  assert_lkp_capped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |-> (lkp_util <= CAP));

endmodule

bind probe_besthop_table pbh_checker #(
  .DEST_W   (DEST_W),
  .UTIL_W   (UTIL_W),
  .UTIL_CAP (UTIL_CAP)
) u_pbh_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .probe_valid (probe_valid),
  .probe_ready (probe_ready),
  .probe_dest  (probe_dest),
  .probe_util  (probe_util),
  .upd_valid   (upd_valid),
  .upd_dest    (upd_dest),
  .upd_util    (upd_util),
  .lkp_valid   (lkp_valid),
  .lkp_util    (lkp_util)
);

// File: tb/probe_besthop_table_test.sv
module probe_besthop_table_test;

  localparam int NP = 4;
  localparam int UW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          probe_valid = 1'b0;
  logic          probe_ready;
  logic [3:0]    probe_dest = '0;
  logic [1:0]    probe_port = '0;
  logic [7:0]    probe_util = '0;
  logic [31:0]   link_util = '0;
  logic          upd_valid;
  logic [3:0]    upd_dest;
  logic [7:0]    upd_util;
  logic [3:0]    lkp_dest = '0;
  logic          lkp_valid;
  logic [1:0]    lkp_hop;
  logic [7:0]    lkp_util;

  always #5 clk = ~clk;

  probe_besthop_table uut (
    .clk (clk), .rst_n (rst_n),
    .probe_valid (probe_valid), .probe_ready (probe_ready),
    .probe_dest (probe_dest), .probe_port (probe_port), .probe_util (probe_util),
    .link_util (link_util),
    .upd_valid (upd_valid), .upd_dest (upd_dest), .upd_util (upd_util),
    .lkp_dest (lkp_dest), .lkp_valid (lkp_valid), .lkp_hop (lkp_hop), .lkp_util (lkp_util)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Fields: dest, port, probe util, link util of that port,
  //         expect update, expected hop, expected stored util
  localparam int NV = 13;
  localparam logic [32:0] VEC [NV] = '{
    {4'd3,  2'd1, 8'd40,  8'd20,  1'b1, 2'd1, 8'd40},  // R4 install, R3 probe dominates
    {4'd3,  2'd2, 8'd50,  8'd10,  1'b0, 2'd1, 8'd40},  // R6 worse from other port
    {4'd3,  2'd2, 8'd30,  8'd35,  1'b1, 2'd2, 8'd35},  // R5 better, R3 link dominates
    {4'd3,  2'd0, 8'd35,  8'd0,   1'b0, 2'd2, 8'd35},  // R6 tie keeps hop
    {4'd3,  2'd2, 8'd70,  8'd5,   1'b1, 2'd2, 8'd70},  // R7 refresh to worse value
    {4'd3,  2'd2, 8'd70,  8'd70,  1'b0, 2'd2, 8'd70},  // R8 same hop, same value: no update
    {4'd9,  2'd3, 8'd200, 8'd0,   1'b1, 2'd3, 8'd100}, // R3 clamp, R4 install at cap
    {4'd9,  2'd0, 8'd100, 8'd150, 1'b0, 2'd3, 8'd100}, // R6 tie at cap after clamp
    {4'd9,  2'd1, 8'd99,  8'd99,  1'b1, 2'd1, 8'd99},  // R5 one below cap
    {4'd3,  2'd0, 8'd0,   8'd60,  1'b1, 2'd0, 8'd60},  // R10 dest 3 unaffected by dest 9
    {4'd15, 2'd0, 8'd0,   8'd0,   1'b1, 2'd0, 8'd0},   // R4 install zero at top index
    {4'd15, 2'd1, 8'd0,   8'd0,   1'b0, 2'd0, 8'd0},   // R6 tie at zero
    {4'd0,  2'd3, 8'd255, 8'd255, 1'b1, 2'd3, 8'd100}  // R3 both operands clamp
  };

  task automatic drive(int d, int p, int pu, int lu, bit v);
    probe_valid = v;
    probe_dest  = d[3:0];
    probe_port  = p[1:0];
    probe_util  = pu[7:0];
    for (int i = 0; i < NP; i++)
      link_util[i*UW +: UW] = (i == p) ? lu[7:0] : 8'd90;
  endtask

  task automatic wait_ready();
    while (probe_ready !== 1'b1) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", probe_ready, 0);
    chk("R1 lookup empty in reset", lkp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready low during release", probe_ready, 0);
    wait_ready();
    for (int d = 0; d < 16; d += 5) begin
      lkp_dest = d[3:0];
      @(negedge clk);
      chk("R1 entry empty after reset", lkp_valid, 0);
    end

    // Vector table
    for (int k = 0; k < NV; k++) begin
      logic [32:0] v;
      v = VEC[k];
      @(negedge clk);
      drive(v[32:29], v[28:27], v[26:19], v[18:11], 1'b1);
      @(negedge clk);
      probe_valid = 1'b0;
      chk("R8 update strobe", upd_valid, v[10]);
      if (v[10]) begin
        chk("R8 update dest", upd_dest, v[32:29]);
        chk("R8 update util", upd_util, v[7:0]);
      end
      lkp_dest = v[32:29];
      @(negedge clk);
      chk("R9 lookup valid", lkp_valid, 1);
      chk("R9 lookup hop", lkp_hop, v[9:8]);
      chk("R9 lookup util", lkp_util, v[7:0]);
    end

    // R2: probe_valid low has no effect
    drive(5, 0, 10, 10, 1'b0);
    @(negedge clk);
    chk("R2 idle cycle raises no update", upd_valid, 0);
    lkp_dest = 4'd5;
    @(negedge clk);
    chk("R2 idle cycle leaves entry empty", lkp_valid, 0);
    chk("R2 ready held high", probe_ready, 1);

    // R2: back-to-back probes to one destination
    drive(7, 1, 50, 0, 1'b1);
    @(negedge clk);
    chk("R2 first back-to-back update", upd_valid, 1);
    chk("R2 first back-to-back util", upd_util, 50);
    drive(7, 2, 40, 0, 1'b1);
    @(negedge clk);
    probe_valid = 1'b0;
    chk("R2 second back-to-back update", upd_valid, 1);
    chk("R5 second back-to-back util", upd_util, 40);
    lkp_dest = 4'd7;
    @(negedge clk);
    chk("R2 back-to-back final hop", lkp_hop, 2);
    chk("R9 lookup holds prior state", lkp_util, 40);
    @(negedge clk);
    chk("R8 strobe lasts one cycle", upd_valid, 0);

    // R9: lookup shows state before the writing edge
    lkp_dest = 4'd7;
    drive(7, 2, 20, 0, 1'b1);
    @(negedge clk);
    probe_valid = 1'b0;
    chk("R9 lookup lags write by one edge", lkp_util, 40);
    @(negedge clk);
    chk("R7 refresh to better from same hop", lkp_util, 20);

    // R1: reset in mid-run empties the table
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 ready drops on reset", probe_ready, 0);
    rst_n = 1'b1;
    lkp_dest = 4'd3;
    wait_ready();
    @(negedge clk);
    chk("R1 entry cleared by reset", lkp_valid, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule